// File: doc/BRIEF.md
# Multi-Lane PHY Power Sequencer

This block brings a PHY that several lanes share out of reset and back into it. Each lane raises a request with an on/off flag and holds it until it receives a one-cycle completion pulse, which comes with an error flag. Requests are taken one at a time, and a shared count tracks how many lanes hold the PHY powered. Only the first power-on and the last power-off touch the PHY reset. Every other request is acknowledged or only updates that lane's idle bit.

The first power-on runs a three-phase PLL bring-up. It releases the reset, pulses a lock request and clears the lane's idle bit, then waits for lock. It then makes two strobed writes of clock parameters through an indirect configuration port, waits for the PLL-output status to clear, issues a second lock request and waits for relock. Each wait has a cycle timeout. When a timeout expires, the sequencer puts the PHY back in reset and reports an error. On the last power-off, a reset-failure input can report that the reset did not take hold. In that case the sequencer releases the reset again and re-enables the lane.

States:
- `ST_IDLE` arbitrates. It either finishes a request at once or moves to `ST_RELEASE` (first power-on) or to `ST_OFF_CHECK` (last power-off).
- `ST_RELEASE` always moves to `ST_WAIT_LOCK`.
- `ST_WAIT_LOCK` moves to `ST_CFG_SETUP` on lock, or to `ST_IDLE` on timeout.
- `ST_CFG_SETUP`, `ST_CFG_STROBE` and `ST_CFG_HOLD` form one parameter write. The hold state loops back to setup for the second write, then moves to `ST_WAIT_OUT`.
- `ST_WAIT_OUT` moves to `ST_RELOCK` when the output status clears, or to `ST_IDLE` on timeout.
- `ST_RELOCK` moves to `ST_WAIT_RELOCK`.
- `ST_WAIT_RELOCK` moves to `ST_IDLE` on lock or on timeout.
- `ST_OFF_CHECK` always moves to `ST_IDLE`.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset the PHY reset output is 1 and every lane idle bit is 1 (bit i = 1 means lane i is idle). No done bit, error, lock request or configuration strobe is active.
- R2: When several lanes request together, the lowest-numbered lane is served first. Only one request is in progress at a time, and no grant is made in a cycle where done is high.
- R3: A power-on with the count at 0 releases the PHY reset, pulses the lock request for one cycle and clears the lane's idle bit, then waits for the PLL-locked input.
- R4: After lock, two parameter writes follow, in this order: address 0x10 with data 4'b1000, then address 0x12 with data 4'b1000. For each write, address and data are set up with the strobe low, the strobe is high for one cycle with address and data held, and then the strobe goes low again.
- R5: After the writes, the sequencer waits for the PLL-output-busy input to be 0, pulses the lock request a second time and waits for lock. The request then completes without error and the count becomes 1.
- R6: A power-on with the count above 0 completes without error, raises the count, and produces no lock request, no configuration write and no reset or idle change.
- R7: A power-off with the count above 0 sets the lane's idle bit. With the count above 1, it lowers the count and completes without error, leaving the reset released.
- R8: A power-off that takes the count from 1 to 0 asserts the PHY reset.
- R9: Each wait lasts at most TMO_CYCLES cycles. On expiry the PHY reset is asserted, done comes with error, and the count stays at 0, so a later power-on runs the full bring-up again.
- R10: If the reset-failure input is high during the last power-off check, the reset is released again, the lane's idle bit is cleared, done comes with error, and the count stays at 1.
- R11: A power-off with the count at 0 completes with error and changes neither the reset nor any idle bit.
- R12: Done is one-hot and lasts one cycle per request. The error flag is only high together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NLANE | Per-lane request, held until that lane's done |
| req_on_i | input | NLANE | Per-lane operation: 1 power-on, 0 power-off |
| done_o | output | NLANE | One-cycle completion pulse per lane |
| err_o | output | 1 | Error flag, valid with done |
| phy_rst_o | output | 1 | PHY reset, 1 = held in reset |
| lane_idle_o | output | NLANE | Lane idle bits, 1 = lane idle |
| pll_lock_req_o | output | 1 | One-cycle PLL lock request |
| cfg_addr_o | output | CFG_AW | Configuration port address |
| cfg_data_o | output | CFG_DW | Configuration port data |
| cfg_strobe_o | output | 1 | Configuration write strobe |
| pll_locked_i | input | 1 | PLL locked status |
| pll_out_busy_i | input | 1 | PLL output enable pending (wait for 0) |
| rst_fail_i | input | 1 | Reset assertion failed, sampled in the off check |

## Verification
A model PLL grants lock to a set number of lock requests and drops lock while a request is pending. Setting that number to 0, 1 or 2 separates a first-lock timeout, a relock timeout and a full bring-up, so each wait is tested on its own. The vector walk mixes first, later and last power requests across lanes, and a power-off with nothing powered. It separates bring-up requests from bare acknowledges by counting lock pulses and strobes per request. Directed cases cover a busy output status, two lanes requesting at once, and a failed reset on the last power-off. Each of these directed cases is followed by a request whose outcome shows whether the count was kept.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_WAIT_LOCK,
        ST_CFG_SETUP,
        ST_CFG_STROBE,
        ST_CFG_HOLD,
        ST_WAIT_OUT,
        ST_RELOCK,
        ST_WAIT_RELOCK,
        ST_OFF_CHECK
    } seq_state_t;

endpackage

// File: rtl/pwr_lane_arb.sv
module pwr_lane_arb #(
    parameter int NLANE = 4,
    localparam int LW = (NLANE > 1) ? $clog2(NLANE) : 1
) (
    input  logic [NLANE-1:0] req,
    input  logic             en,
    output logic [NLANE-1:0] gnt_oh,
    output logic [LW-1:0]    gnt_idx,
    output logic             gnt_vld
);

    // scan from the top so the lowest index wins
    always_comb begin
        gnt_oh  = '0;
        gnt_idx = '0;
        for (int i = NLANE - 1; i >= 0; i--) begin
            if (en && req[i]) begin
                gnt_oh    = '0;
                gnt_oh[i] = 1'b1;
                gnt_idx   = LW'(i);
            end
        end
    end

    assign gnt_vld = |gnt_oh;

endmodule

// File: rtl/pwr_wait_timer.sv
module pwr_wait_timer #(
    parameter int LIMIT = 1000,
    localparam int TW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= TW'(LIMIT - 1);
        else if (remain != '0)
            remain <= remain - TW'(1);
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
    import phy_seq_pkg::*;
#(
    parameter int NLANE      = 4,
    parameter int TMO_CYCLES = 100000,
    parameter int CFG_AW     = 6,
    parameter int CFG_DW     = 4,
    parameter logic [CFG_AW-1:0] ADDR_FIRST  = 6'h10,
    parameter logic [CFG_AW-1:0] ADDR_SECOND = 6'h12,
    parameter logic [CFG_DW-1:0] PARAM_DATA  = 4'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLANE-1:0]  req_i,
    input  logic [NLANE-1:0]  req_on_i,
    output logic [NLANE-1:0]  done_o,
    output logic              err_o,
    output logic              phy_rst_o,
    output logic [NLANE-1:0]  lane_idle_o,
    output logic              pll_lock_req_o,
    output logic [CFG_AW-1:0] cfg_addr_o,
    output logic [CFG_DW-1:0] cfg_data_o,
    output logic              cfg_strobe_o,
    input  logic              pll_locked_i,
    input  logic              pll_out_busy_i,
    input  logic              rst_fail_i
);

    localparam int LW = (NLANE > 1) ? $clog2(NLANE) : 1;
    localparam int CW = $clog2(NLANE + 1);

    seq_state_t        state, nxt;
    logic [CW-1:0]     pwr_cnt;
    logic [LW-1:0]     cur_lane;
    logic              wr_sel;
    logic              tmr_load, tmr_expired;
    logic [NLANE-1:0]  gnt_oh;
    logic [LW-1:0]     gnt_idx;
    logic              gnt_vld, gnt_on;

    pwr_lane_arb #(.NLANE(NLANE)) i_arb (
        .req     (req_i),
        .en      ((state == ST_IDLE) && !(|done_o)),
        .gnt_oh  (gnt_oh),
        .gnt_idx (gnt_idx),
        .gnt_vld (gnt_vld)
    );

    pwr_wait_timer #(.LIMIT(TMO_CYCLES)) i_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    assign gnt_on = req_on_i[gnt_idx];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (gnt_vld) begin
                    if (gnt_on && pwr_cnt == '0)
                        nxt = ST_RELEASE;
                    else if (!gnt_on && pwr_cnt == CW'(1))
                        nxt = ST_OFF_CHECK;
                end
            end
            ST_RELEASE: begin
                nxt      = ST_WAIT_LOCK;
                tmr_load = 1'b1;
            end
            ST_WAIT_LOCK: begin
                if (pll_locked_i)     nxt = ST_CFG_SETUP;
                else if (tmr_expired) nxt = ST_IDLE;
            end
            ST_CFG_SETUP:  nxt = ST_CFG_STROBE;
            ST_CFG_STROBE: nxt = ST_CFG_HOLD;
            ST_CFG_HOLD: begin
                if (wr_sel) begin
                    nxt      = ST_WAIT_OUT;
                    tmr_load = 1'b1;
                end else begin
                    nxt = ST_CFG_SETUP;
                end
            end
            ST_WAIT_OUT: begin
                if (!pll_out_busy_i)  nxt = ST_RELOCK;
                else if (tmr_expired) nxt = ST_IDLE;
            end
            ST_RELOCK: begin
                nxt      = ST_WAIT_RELOCK;
                tmr_load = 1'b1;
            end
            ST_WAIT_RELOCK: begin
                if (pll_locked_i || tmr_expired) nxt = ST_IDLE;
            end
            ST_OFF_CHECK: nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // registered outputs and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o         <= '0;
            err_o          <= 1'b0;
            phy_rst_o      <= 1'b1;
            lane_idle_o    <= '1;
            pll_lock_req_o <= 1'b0;
            cfg_addr_o     <= '0;
            cfg_data_o     <= '0;
            cfg_strobe_o   <= 1'b0;
            pwr_cnt        <= '0;
            cur_lane       <= '0;
            wr_sel         <= 1'b0;
        end else begin
            done_o         <= '0;
            err_o          <= 1'b0;
            pll_lock_req_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (gnt_vld) begin
                        cur_lane <= gnt_idx;
                        if (gnt_on) begin
                            if (pwr_cnt != '0) begin
                                pwr_cnt         <= pwr_cnt + CW'(1);
                                done_o[gnt_idx] <= 1'b1;
                            end
                        end else if (pwr_cnt == '0) begin
                            done_o[gnt_idx] <= 1'b1;
                            err_o           <= 1'b1;
                        end else begin
                            lane_idle_o[gnt_idx] <= 1'b1;
                            if (pwr_cnt == CW'(1)) begin
                                phy_rst_o <= 1'b1;
                            end else begin
                                pwr_cnt         <= pwr_cnt - CW'(1);
                                done_o[gnt_idx] <= 1'b1;
                            end
                        end
                    end
                end
                ST_RELEASE: begin
                    phy_rst_o             <= 1'b0;
                    pll_lock_req_o        <= 1'b1;
                    lane_idle_o[cur_lane] <= 1'b0;
                    wr_sel                <= 1'b0;
                end
                ST_WAIT_LOCK, ST_WAIT_OUT: begin
                    if (((state == ST_WAIT_LOCK) ? !pll_locked_i : pll_out_busy_i)
                        && tmr_expired) begin
                        phy_rst_o        <= 1'b1;
                        done_o[cur_lane] <= 1'b1;
                        err_o            <= 1'b1;
                    end
                end
                ST_CFG_SETUP: begin
                    cfg_addr_o   <= wr_sel ? ADDR_SECOND : ADDR_FIRST;
                    cfg_data_o   <= PARAM_DATA;
                    cfg_strobe_o <= 1'b0;
                end
                ST_CFG_STROBE: cfg_strobe_o <= 1'b1;
                ST_CFG_HOLD: begin
                    cfg_strobe_o <= 1'b0;
                    wr_sel       <= 1'b1;
                end
                ST_RELOCK: pll_lock_req_o <= 1'b1;
                ST_WAIT_RELOCK: begin
                    if (pll_locked_i) begin
                        pwr_cnt          <= pwr_cnt + CW'(1);
                        done_o[cur_lane] <= 1'b1;
                    end else if (tmr_expired) begin
                        phy_rst_o        <= 1'b1;
                        done_o[cur_lane] <= 1'b1;
                        err_o            <= 1'b1;
                    end
                end
                ST_OFF_CHECK: begin
                    done_o[cur_lane] <= 1'b1;
                    if (rst_fail_i) begin
                        phy_rst_o             <= 1'b0;
                        lane_idle_o[cur_lane] <= 1'b0;
                        err_o                 <= 1'b1;
                    end else begin
                        pwr_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh));

    // R12
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o));

    // R12
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (|done_o));

    // R4
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe_o |-> ($stable(cfg_addr_o) && $stable(cfg_data_o)));

    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe_o |=> !cfg_strobe_o);

    // R3
    lock_out_of_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_lock_req_o |-> !phy_rst_o);

    // R9
    abort_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(phy_rst_o) && err_o) |-> $stable(pwr_cnt));

endmodule

// File: tb/test_phy_pwr_seq.sv
`timescale 1ns/1ps
module test_phy_pwr_seq;

    localparam int NLANE = 4;
    localparam int TMO   = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NLANE-1:0] req = '0;
    logic [NLANE-1:0] req_on = '0;
    logic [NLANE-1:0] done;
    logic             err, phy_rst, lock_req, strobe;
    logic [NLANE-1:0] idle;
    logic [5:0]       addr;
    logic [3:0]       data;
    logic             locked;
    logic             busy = 1'b0;
    logic             rst_fail = 1'b0;

    int errors = 0;
    int checks = 0;
    int grants = 2;
    int seen = 0;
    int lock_total = 0;
    int wr_n = 0;
    logic [5:0] wr_addr [0:63];
    logic [3:0] wr_data [0:63];
    int cycles = 0;

    always #2.5 clk = ~clk;

    phy_pwr_seq #(.NLANE(NLANE), .TMO_CYCLES(TMO)) i_phy_pwr_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_on_i(req_on),
        .done_o(done), .err_o(err), .phy_rst_o(phy_rst), .lane_idle_o(idle),
        .pll_lock_req_o(lock_req), .cfg_addr_o(addr), .cfg_data_o(data),
        .cfg_strobe_o(strobe), .pll_locked_i(locked),
        .pll_out_busy_i(busy), .rst_fail_i(rst_fail)
    );

    // PLL model: grants lock to the first `grants` requests after reset release
    always @(posedge clk) begin
        if (!rst_n || phy_rst) seen <= 0;
        else if (lock_req) seen <= seen + 1;
        if (lock_req) lock_total <= lock_total + 1;
        if (strobe && wr_n < 64) begin
            wr_addr[wr_n] <= addr;
            wr_data[wr_n] <= data;
            wr_n <= wr_n + 1;
        end
    end
    assign locked = !lock_req && (seen > 0) && (seen <= grants);

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_req(input int lane, input bit on, output bit e, output int cyc);
        @(negedge clk);
        req[lane]    = 1'b1;
        req_on[lane] = on;
        cyc = 0;
        while (!done[lane] && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        e = err;
        req[lane] = 1'b0;
        chk(done[lane] == 1'b1, "R12 done arrives", int'(done[lane]), 1);
        @(negedge clk);
        chk(done == '0 && err == 1'b0, "R12 done one cycle", int'(done), 0);
    endtask

    task automatic chk_writes(input int base, input string tag);
        chk(wr_n == base + 2, {tag, " write count"}, wr_n, base + 2);
        if (wr_n == base + 2) begin
            chk(wr_addr[base] == 6'h10 && wr_data[base] == 4'h8, {tag, " first write"},
                int'({wr_addr[base], wr_data[base]}), int'({6'h10, 4'h8}));
            chk(wr_addr[base+1] == 6'h12 && wr_data[base+1] == 4'h8, {tag, " second write"},
                int'({wr_addr[base+1], wr_data[base+1]}), int'({6'h12, 4'h8}));
        end
    endtask

    // {lane[9:8], on[7], err[6], rst[5], bringup[4], idle[3:0]}
    localparam logic [9:0] VEC [0:6] = '{
        {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1110},
        {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1110},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1111},
        {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 4'b1111},
        {2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1111},
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0111},
        {2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 4'b1111}
    };

    initial begin
        bit e;
        int cyc, l0, w0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(phy_rst == 1'b1, "R1 reset asserted", int'(phy_rst), 1);
        chk(idle == 4'b1111, "R1 idle bits", int'(idle), 15);
        chk(done == '0 && err == 1'b0 && lock_req == 1'b0 && strobe == 1'b0,
            "R1 quiet outputs", int'({done, err, lock_req, strobe}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < 7; k++) begin
            l0 = lock_total;
            w0 = wr_n;
            do_req(int'(VEC[k][9:8]), VEC[k][7], e, cyc);
            chk(e == VEC[k][6], $sformatf("R11 R7 vec%0d error flag", k), int'(e), int'(VEC[k][6]));
            chk(phy_rst == VEC[k][5], $sformatf("R8 R3 vec%0d reset", k), int'(phy_rst), int'(VEC[k][5]));
            chk(idle == VEC[k][3:0], $sformatf("R7 R3 vec%0d idle", k), int'(idle), int'(VEC[k][3:0]));
            if (VEC[k][4]) begin
                chk(lock_total == l0 + 2, $sformatf("R5 vec%0d two lock requests", k), lock_total, l0 + 2);
                chk_writes(w0, "R4");
            end else begin
                chk(lock_total == l0 && wr_n == w0, $sformatf("R6 vec%0d no bring-up", k),
                    lock_total - l0 + wr_n - w0, 0);
            end
        end

        // R9 first lock never comes
        grants = 0;
        l0 = lock_total;
        do_req(1, 1'b1, e, cyc);
        chk(e == 1'b1, "R9 lock timeout error", int'(e), 1);
        chk(phy_rst == 1'b1, "R9 reset after lock timeout", int'(phy_rst), 1);
        chk(cyc >= TMO && cyc <= TMO + 6, "R9 timeout length", cyc, TMO + 2);
        chk(lock_total == l0 + 1, "R9 single lock request", lock_total - l0, 1);
        // R9 count stayed at 0: full bring-up again
        grants = 2;
        l0 = lock_total;
        w0 = wr_n;
        do_req(1, 1'b1, e, cyc);
        chk(e == 1'b0 && phy_rst == 1'b0, "R9 retry succeeds", int'({e, phy_rst}), 0);
        chk(lock_total == l0 + 2, "R9 retry reruns bring-up", lock_total - l0, 2);
        do_req(1, 1'b0, e, cyc);
        chk(phy_rst == 1'b1, "R8 reset after last off", int'(phy_rst), 1);

        // R9 relock never comes
        grants = 1;
        l0 = lock_total;
        w0 = wr_n;
        do_req(1, 1'b1, e, cyc);
        chk(e == 1'b1 && phy_rst == 1'b1, "R9 relock timeout", int'({e, phy_rst}), 3);
        chk(lock_total == l0 + 2, "R5 relock was requested", lock_total - l0, 2);
        chk_writes(w0, "R4 before relock");

        // R9 output status stays busy
        grants = 2;
        busy = 1'b1;
        l0 = lock_total;
        w0 = wr_n;
        do_req(1, 1'b1, e, cyc);
        chk(e == 1'b1 && phy_rst == 1'b1, "R9 output busy timeout", int'({e, phy_rst}), 3);
        chk(lock_total == l0 + 1, "R5 no relock while busy", lock_total - l0, 1);
        busy = 1'b0;

        // R2 two lanes at once
        l0 = lock_total;
        @(negedge clk);
        req[3] = 1'b1; req_on[3] = 1'b1;
        req[1] = 1'b1; req_on[1] = 1'b1;
        cyc = 0;
        while (done == '0 && cyc < 2000) begin @(negedge clk); cyc++; end
        chk(done == 4'b0010, "R2 lowest lane served first", int'(done), 2);
        req[1] = 1'b0;
        cyc = 0;
        while (!done[3] && cyc < 2000) begin @(negedge clk); cyc++; end
        chk(done == 4'b1000 && err == 1'b0, "R2 second lane acknowledged", int'({done, err}), 16);
        req[3] = 1'b0;
        @(negedge clk);
        chk(lock_total == l0 + 2, "R6 second lane adds no bring-up", lock_total - l0, 2);

        // R10 reset fails on last off
        do_req(3, 1'b0, e, cyc);
        chk(e == 1'b0 && phy_rst == 1'b0, "R7 off with count 2", int'({e, phy_rst}), 0);
        rst_fail = 1'b1;
        do_req(1, 1'b0, e, cyc);
        rst_fail = 1'b0;
        chk(e == 1'b1, "R10 failed off reports error", int'(e), 1);
        chk(phy_rst == 1'b0, "R10 reset released again", int'(phy_rst), 0);
        chk(idle[1] == 1'b0, "R10 lane re-enabled", int'(idle[1]), 0);
        do_req(1, 1'b0, e, cyc);
        chk(e == 1'b0 && phy_rst == 1'b1, "R10 count kept at 1", int'({e, phy_rst}), 1);

        summary();
    end

endmodule